// File: doc/BRIEF.md
# Compare-and-Edge Timer Peripheral

This block is a small timer that sits on a 4-bit register bus. An 8-bit up-counter advances on a selectable division of the timer clock enable. Two compare registers watch the counter. A match on the first compare register raises a flag. A match on the second compare register raises its own flag, returns the counter to zero and inverts a toggle output pin. While the timer is stopped, software can force the toggle output to a chosen level. It can also ask for the output to invert once at the moment the timer starts.

A separate input pin is synchronised and watched for a rising edge, a falling edge, either edge, or no edge at all. A detected edge sets a third flag and, when unmasked, pulses an interrupt. The three flags are sticky. They read back together from the same address used to write the control bits, and the read itself clears them.

Register map used by the bus:
- Address 0xC, write: control register.
- Address 0xC, read: flags.
- Address 0xB, subaddress 1: mode register.
- Address 0xB, subaddresses 2 and 3: compare register 1, low nibble then high nibble.
- Address 0xB, subaddresses 4 and 5: compare register 2, low nibble then high nibble.

Top module: `cmp_edge_timer`

## Requirements
- R1: After reset the control register is 0000, the toggle output is 0, the interrupt is 0, the flags read 000, and the mode register is 1111 (edge detection off, divide by 8).
- R2: While the run bit (control bit 0) is 0 the counter is held at zero and no compare flag can set. While run is 1 the counter advances only on cycles where the tick enable input is high and the divider allows a step.
- R3: Mode bits 1:0 pick the step rate from the tick enable: 00 every tick, 01 every 2nd, 10 every 4th, 11 every 8th. The divider restarts when the timer is started.
- R4: On a counter step where the counter equals compare register 1, the compare-1 flag (read bit 0) sets.
- R5: On a counter step where the counter equals compare register 2, the compare-2 flag (read bit 1) sets, the counter reloads to zero, and the toggle output inverts.
- R6: A control write made while the timer is stopped drives the toggle output to control bit 2. A control write made while the timer is running leaves the output unchanged.
- R7: A control write that starts a stopped timer with control bit 1 set inverts the output once relative to the preset level. With bit 1 clear, starting the timer does not toggle the output.
- R8: A read at address 0xC returns {0, edge flag, compare-2 flag, compare-1 flag} and clears all three flags at the end of the access.
- R9: If a flag-setting event falls in the same cycle as a flags read, the flag stays set after the read.
- R10: The edge pin passes through a two-stage synchroniser. Mode bits 3:2 choose the edge that sets the edge flag (read bit 2): 10 rising, 01 falling, 00 both, 11 none.
- R11: The interrupt output is high for one cycle on each detected edge when control bit 3 is 1, and stays low when bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_sub | input | 4 | Subaddress within the 0xB bank |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid while the read strobe is high |
| tick_en | input | 1 | Timer clock enable feeding the divider |
| edge_pin | input | 1 | Asynchronous edge input |
| tgl_out | output | 1 | Toggle output pin |
| irq | output | 1 | Edge interrupt pulse |

## Verification
The hardest situation to reach from the ports is a compare match that lands in exactly the cycle of a flags read, because the match time depends on the divider phase and the compare value. The stimulus gets there by restarting the timer, which clears both the counter and the divider. It then counts the cycles until the step at which the counter equals compare register 1, for each of the four rates. It issues a read whose strobe covers that edge and expects 000. A second read then expects the compare-1 flag to have survived.

// File: rtl/cet_pkg.sv
package cet_pkg;

  localparam int DATA_W = 4;
  localparam int DIV_W  = 3;

  typedef struct packed {
    logic mask;
    logic preset;
    logic tstart;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    EDG_BOTH = 2'b00,
    EDG_FALL = 2'b01,
    EDG_RISE = 2'b10,
    EDG_OFF  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e  esel;
    logic [1:0] csel;
  } mode_t;

  // A step is due when the low divider bits selected by csel are all ones.
  function automatic logic step_due(input logic [1:0] csel, input logic [DIV_W-1:0] div);
    case (csel)
      2'd0:    return 1'b1;
      2'd1:    return div[0];
      2'd2:    return &div[1:0];
      default: return &div;
    endcase
  endfunction

  function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
    case (sel)
      EDG_RISE: return cur & ~prev;
      EDG_FALL: return ~cur & prev;
      EDG_BOTH: return cur ^ prev;
      default:  return 1'b0;
    endcase
  endfunction

  // Output level after a control write made while stopped.
  function automatic logic preset_level(input ctrl_t w);
    return w.preset ^ (w.run & w.tstart);
  endfunction

endpackage

// File: rtl/cet_regs.sv
module cet_regs
  import cet_pkg::*;
#(
  parameter int          CMP_W     = 8,
  parameter logic [3:0]  ADDR_CTRL = 4'hC,
  parameter logic [3:0]  ADDR_BANK = 4'hB,
  parameter int          SUB_MODE  = 1,
  parameter int          SUB_C1    = 2,
  parameter int          SUB_C2    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic [3:0]        sub,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output mode_t             mode,
  output logic [CMP_W-1:0]  cmp1,
  output logic [CMP_W-1:0]  cmp2,
  output logic              preset_we,
  output logic              preset_val
);
  localparam int NIB = CMP_W / DATA_W;

  logic ctrl_wr, bank_wr;
  assign ctrl_wr = wr && (addr == ADDR_CTRL);
  assign bank_wr = wr && (addr == ADDR_BANK);

  // Preset is only honoured while the stored run bit is clear.
  assign preset_we  = ctrl_wr && !ctrl.run;
  assign preset_val = preset_level(ctrl_t'(wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= ctrl_t'('0);
      mode <= mode_t'(4'hF);
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wdata);
      if (bank_wr && sub == 4'(SUB_MODE)) mode <= mode_t'(wdata);
    end
  end

  logic [DATA_W-1:0] c1_nib [NIB];
  logic [DATA_W-1:0] c2_nib [NIB];

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c1_nib[i] <= '0;
        c2_nib[i] <= '0;
      end else begin
        if (bank_wr && sub == 4'(SUB_C1 + i)) c1_nib[i] <= wdata;
        if (bank_wr && sub == 4'(SUB_C2 + i)) c2_nib[i] <= wdata;
      end
    end
    assign cmp1[i*DATA_W +: DATA_W] = c1_nib[i];
    assign cmp2[i*DATA_W +: DATA_W] = c2_nib[i];
  end

endmodule

// File: rtl/cet_count.sv
module cet_count
  import cet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic [1:0]       csel,
  input  logic [CNT_W-1:0] cmp1,
  input  logic [CNT_W-1:0] cmp2,
  input  logic             preset_we,
  input  logic             preset_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tgl,
  output logic             hit1,
  output logic             hit2
);
  logic [DIV_W-1:0] div_q;
  logic             step;

  assign step = run && tick_en && step_due(csel, div_q);
  assign hit1 = step && (cnt == cmp1);
  assign hit2 = step && (cnt == cmp2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      tgl   <= 1'b0;
    end else begin
      if (!run) begin
        div_q <= '0;
        cnt   <= '0;
      end else begin
        if (tick_en) div_q <= div_q + 1'b1;
        if (hit2)      cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
      end
      if (preset_we) tgl <= preset_val;
      else if (hit2) tgl <= ~tgl;
    end
  end

  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
  p_hold_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt));
  p_wrap_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit2 |=> (cnt == '0) && (tgl != $past(tgl)));
  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    preset_we |=> tgl == $past(preset_val));

endmodule

// File: rtl/cet_edge.sv
module cet_edge
  import cet_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e esel,
  output logic      evt
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[SYNC_N-1];
  assign evt = edge_hit(esel, cur, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      prev_q <= cur;
    end
  end

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (esel == EDG_OFF) |-> !evt);

endmodule

// File: rtl/cmp_edge_timer.sv
module cmp_edge_timer
  import cet_pkg::*;
#(
  parameter int         CNT_W     = 8,
  parameter int         SYNC_N    = 2,
  parameter logic [3:0] ADDR_CTRL = 4'hC,
  parameter logic [3:0] ADDR_BANK = 4'hB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic [3:0] bus_sub,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       tick_en,
  input  logic       edge_pin,
  output logic       tgl_out,
  output logic       irq
);
  ctrl_t            ctrl;
  mode_t            mode;
  logic [CNT_W-1:0] cmp1, cmp2, cnt;
  logic             preset_we, preset_val;
  logic             hit1, hit2, edge_evt, st_read;
  logic             fl_c1, fl_c2, fl_ed;

  cet_regs #(
    .CMP_W(CNT_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_BANK(ADDR_BANK),
    .SUB_MODE(1), .SUB_C1(2), .SUB_C2(4)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sub(bus_sub), .wr(bus_wr),
    .wdata(bus_wdata), .ctrl(ctrl), .mode(mode), .cmp1(cmp1), .cmp2(cmp2),
    .preset_we(preset_we), .preset_val(preset_val)
  );

  cet_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick_en(tick_en),
    .csel(mode.csel), .cmp1(cmp1), .cmp2(cmp2), .preset_we(preset_we),
    .preset_val(preset_val), .cnt(cnt), .tgl(tgl_out), .hit1(hit1), .hit2(hit2)
  );

  cet_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(edge_pin), .esel(mode.esel), .evt(edge_evt)
  );

  assign st_read   = bus_rd && (bus_addr == ADDR_CTRL);
  assign bus_rdata = st_read ? {1'b0, fl_ed, fl_c2, fl_c1} : 4'b0000;
  assign irq       = edge_evt && ctrl.mask;

  // A set in the same cycle as a read takes priority over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_c1 <= 1'b0;
      fl_c2 <= 1'b0;
      fl_ed <= 1'b0;
    end else begin
      if (hit1)          fl_c1 <= 1'b1;
      else if (st_read)  fl_c1 <= 1'b0;
      if (hit2)          fl_c2 <= 1'b1;
      else if (st_read)  fl_c2 <= 1'b0;
      if (edge_evt)      fl_ed <= 1'b1;
      else if (st_read)  fl_ed <= 1'b0;
    end
  end

  p_c1_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> fl_c1);
  p_c2_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit2 |=> fl_c2);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_read && !hit1 && !hit2 && !edge_evt) |=> !fl_c1 && !fl_c2 && !fl_ed);
  p_edge_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> fl_ed);
  p_irq_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: tb/cmp_edge_timer_test.sv
`timescale 1ns/1ps
module cmp_edge_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0, bus_sub = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_rdata;
  logic       tick_en = 1'b0, edge_pin = 1'b0;
  logic       tgl_out, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  cmp_edge_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_sub(bus_sub),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .edge_pin(edge_pin), .tgl_out(tgl_out), .irq(irq)
  );

  // Monitor: compares each flags read against the scoreboard queue.
  logic [3:0] mon_exp;
  string      mon_tag;
  always @(negedge clk) begin
    if (bus_rd) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected read: actual=%b expected=<none>", bus_rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        if (bus_rdata !== mon_exp) begin
          n_fail++;
          $display("FAIL %s flags read: actual=%b expected=%b", mon_tag, bus_rdata, mon_exp);
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [3:0] s, input logic [3:0] d);
    bus_addr = a; bus_sub = s; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // Driver: pushes the expected flags, then performs the read.
  task automatic rd_flags(input logic [3:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = 4'hC; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_cmp(input int base, input logic [7:0] v);
    wr_reg(4'hB, 4'(base),     v[3:0]);
    wr_reg(4'hB, 4'(base + 1), v[7:4]);
  endtask

  // Restart, then read across the edge where the step with count == 1 occurs.
  task automatic rate_test(input logic [1:0] sel, input int d, input bit set_mode);
    wr_reg(4'hC, 4'h0, 4'b0000);
    if (set_mode) wr_reg(4'hB, 4'h1, {2'b11, sel});
    wr_reg(4'hC, 4'h0, 4'b0001);
    idle(2 * d - 1);
    rd_flags(4'b000, "R3 no hit before step");
    rd_flags(4'b001, "R9 hit kept over same-cycle read");
  endtask

  task automatic pin_edge(input logic v, input logic exp_irq, input string tag);
    edge_pin = v;
    idle(2);
    check(irq, exp_irq, tag);
    idle(1);
    check(irq, 1'b0, "R11 irq single cycle");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(tgl_out, 1'b0, "R1 toggle out after reset");
    check(irq, 1'b0, "R1 irq after reset");
    rd_flags(4'b000, "R1 flags after reset");

    // Rates; first pass uses the reset mode (divide by 8).
    set_cmp(2, 8'd1);
    set_cmp(4, 8'd200);
    tick_en = 1'b1;
    rate_test(2'b11, 8, 1'b0);
    rate_test(2'b00, 1, 1'b1);
    rate_test(2'b01, 2, 1'b1);
    rate_test(2'b10, 4, 1'b1);

    // R2: tick enable gates counting; stopped timer never flags.
    wr_reg(4'hC, 4'h0, 4'b0000);
    wr_reg(4'hB, 4'h1, 4'b1100);
    set_cmp(2, 8'd0);
    tick_en = 1'b0;
    wr_reg(4'hC, 4'h0, 4'b0001);
    idle(10);
    rd_flags(4'b000, "R2 no step without tick");
    tick_en = 1'b1;
    idle(1);
    rd_flags(4'b001, "R2 first step at zero");
    wr_reg(4'hC, 4'h0, 4'b0000);
    rd_flags(4'b000, "R2 clear before stopped window");
    idle(5);
    rd_flags(4'b000, "R2 stopped holds");

    // R4/R5: compare 1 = 3, compare 2 = 5 at full rate.
    set_cmp(2, 8'd3);
    set_cmp(4, 8'd5);
    wr_reg(4'hC, 4'h0, 4'b0000);
    wr_reg(4'hC, 4'h0, 4'b0001);
    idle(4);
    rd_flags(4'b001, "R4 compare 1 match");
    idle(1);
    check(tgl_out, 1'b1, "R5 toggle on compare 2");
    rd_flags(4'b010, "R5 compare 2 match");
    idle(5);
    check(tgl_out, 1'b0, "R5 second toggle after reload");
    rd_flags(4'b011, "R5 reload to zero period");

    // R6/R7: preset and toggle on start, with the counter idle.
    tick_en = 1'b0;
    wr_reg(4'hC, 4'h0, 4'b0000);
    wr_reg(4'hC, 4'h0, 4'b0100);
    check(tgl_out, 1'b1, "R6 preset 1 while stopped");
    wr_reg(4'hC, 4'h0, 4'b0000);
    check(tgl_out, 1'b0, "R6 preset 0 while stopped");
    wr_reg(4'hC, 4'h0, 4'b0001);
    check(tgl_out, 1'b0, "R7 start without toggle");
    wr_reg(4'hC, 4'h0, 4'b0101);
    check(tgl_out, 1'b0, "R6 preset ignored while running");
    wr_reg(4'hC, 4'h0, 4'b0000);
    wr_reg(4'hC, 4'h0, 4'b0011);
    check(tgl_out, 1'b1, "R7 start toggles from preset 0");
    wr_reg(4'hC, 4'h0, 4'b0000);
    check(tgl_out, 1'b1, "R6 stop write from running keeps level");
    wr_reg(4'hC, 4'h0, 4'b0111);
    check(tgl_out, 1'b0, "R7 start toggles from preset 1");
    wr_reg(4'hC, 4'h0, 4'b1000);

    // R10/R11: edge selection and interrupt mask.
    pin_edge(1'b1, 1'b0, "R10 edge off ignores rise");
    pin_edge(1'b0, 1'b0, "R10 edge off ignores fall");
    rd_flags(4'b000, "R10 edge off no flag");
    wr_reg(4'hB, 4'h1, 4'b1011);
    pin_edge(1'b1, 1'b1, "R11 irq on rising");
    rd_flags(4'b100, "R10 rising flag");
    pin_edge(1'b0, 1'b0, "R10 rising mode ignores fall");
    rd_flags(4'b000, "R10 rising mode no fall flag");
    wr_reg(4'hB, 4'h1, 4'b0111);
    pin_edge(1'b1, 1'b0, "R10 falling mode ignores rise");
    rd_flags(4'b000, "R10 falling mode no rise flag");
    pin_edge(1'b0, 1'b1, "R11 irq on falling");
    rd_flags(4'b100, "R10 falling flag");
    wr_reg(4'hB, 4'h1, 4'b0011);
    pin_edge(1'b1, 1'b1, "R10 both mode rise");
    pin_edge(1'b0, 1'b1, "R10 both mode fall");
    rd_flags(4'b100, "R10 both mode flag");
    wr_reg(4'hC, 4'h0, 4'b0000);
    pin_edge(1'b1, 1'b0, "R11 masked irq stays low");
    rd_flags(4'b100, "R11 masked edge still flags");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule